// File: doc/BRIEF.md
# Serial Port Bit Clock and Frame Sync Generator

This block derives the internal data bit clock and the periodic frame sync pulse of a serial port from one of four input clocks. It is a chain of three programmable counters, all running in the system clock domain. The first divides the selected input clock down to the bit clock. The second sets how many bit clocks make up one frame. The third sets how many bit clocks the frame sync stays high. External clock pins pass through a synchronizer and an edge detector, and the detected edge of the chosen polarity acts as the input clock enable.

In resync mode the generator stops producing periodic frames. It watches an incoming frame sync pin instead. Each detected frame edge restarts the bit clock divider, starts a new output frame and launches the width counter. The whole generator sits idle while its enable input is low. Divider, period and width settings are captured at frame boundaries, so a change made while the generator runs never produces a short or stretched frame.

Top module: `sfg_top`

## Requirements
- R1: While `gen_en` is low, and during reset, `bit_clk` and `frame_sync` are both low. Both read low at the first sample after a clock edge that saw `gen_en` low.
- R2: `src_mode` selects the input clock: 00 is the system clock itself (every system clock is one input clock), 01 is `ext_clk`, 10 is `rxc_pin` and 11 is `txc_pin`. A pin that is not selected has no effect. A selected pin edge reaches `bit_clk` on the third system clock edge after the pin changes.
- R3: The polarity input of the selected pin picks the counted edge: 0 counts rising edges and 1 counts falling edges.
- R4: For a divide value N, one bit clock period lasts N+1 input clocks. Within it, `bit_clk` is high for the first (N+2)/2 input clocks (integer division) and low for the rest.
- R5: After `gen_en` goes high, `bit_clk` first rises on the (N+1)-th input clock.
- R6: Outside resync mode, with a period value P, `frame_sync` rises together with `bit_clk` on the first bit clock after enable and then on every (P+1)-th bit clock.
- R7: With a width value W, `frame_sync` stays high for W+1 bit clock periods from each frame start.
- R8: Changes to `div_val`, `per_val` and `wid_val` while the generator runs take effect at the next frame start. The frame in progress keeps the old values.
- R9: With `sync_en` high, a detected edge on `fs_pin` restarts the divider phase. `fs_pol` 0 detects a rising edge and 1 detects a falling edge. On the third system clock edge after the pin changes, `bit_clk` and `frame_sync` both go high. No periodic frames are produced, and no frame appears before the first detected edge.
- R10: With `sync_en` low, `fs_pin` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generator enable; low holds it idle |
| src_mode | input | 2 | Input clock selection |
| ext_clk | input | 1 | External source clock pin |
| ext_pol | input | 1 | Counted edge of `ext_clk` |
| rxc_pin | input | 1 | Receive clock pin |
| rxc_pol | input | 1 | Counted edge of `rxc_pin` |
| txc_pin | input | 1 | Transmit clock pin |
| txc_pol | input | 1 | Counted edge of `txc_pin` |
| div_val | input | DIV_W | Divide value N |
| per_val | input | FRM_W | Frame period value P |
| wid_val | input | FRM_W | Frame width value W |
| sync_en | input | 1 | Resync-to-incoming-frame mode |
| fs_pin | input | 1 | Incoming frame sync pin |
| fs_pol | input | 1 | Detected edge of `fs_pin` |
| bit_clk | output | 1 | Generated bit clock |
| frame_sync | output | 1 | Generated frame sync |

## Verification
The hardest case to reach is a resync edge that arrives away from the divider's natural wrap point. Only then does the bit clock phase after the edge show whether the divider really reloaded. The bench enables the generator in resync mode and waits a counted number of cycles. It then toggles the frame pin so that detection lands one input clock after a natural wrap. At that phase, a divider that ignored the reload would hold the bit clock high one cycle too few. With a small period value, the bench then keeps watching long enough that any periodic frame would have appeared. A second hard case is a period change made in the middle of a frame. The bench writes the new value just after a frame start and compares every later frame rise against the old and new spacing.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
    typedef enum logic [1:0] {
        SRC_SYS = 2'b00,
        SRC_EXT = 2'b01,
        SRC_RXP = 2'b10,
        SRC_TXP = 2'b11
    } src_sel_e;
endpackage

// File: rtl/sfg_edge.sv
// Two-flop synchronizer followed by a polarity-selected edge detector.
module sfg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic hit
);
    typedef struct packed {
        logic [2:0] sh;
    } edge_st_t;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[1:0], pin};
        hit    = pol ? (~s_q.sh[1] & s_q.sh[2]) : (s_q.sh[1] & ~s_q.sh[2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sfg_bitdiv.sv
// Stage one: input clocks per bit clock, with phase reload on resync.
module sfg_bitdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             resync,
    input  logic [DIV_W-1:0] div,
    output logic             bit_clk,
    output logic             bit_tick
);
    localparam int CW = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             run;
        logic             clk_o;
    } div_st_t;

    div_st_t          s_d, s_q;
    logic [CW-1:0]    half;
    logic             wrap;
    logic [DIV_W-1:0] nxt;

    always_comb begin
        half     = ({1'b0, div} + CW'(2)) >> 1;
        wrap     = tick && (s_q.cnt == div);
        nxt      = wrap ? '0 : s_q.cnt + 1'b1;
        bit_tick = en && (resync || wrap);
        s_d      = s_q;
        if (!en) begin
            s_d = '0;
        end else if (resync) begin
            s_d.cnt   = '0;
            s_d.run   = 1'b1;
            s_d.clk_o = 1'b1;
        end else if (tick) begin
            s_d.cnt   = nxt;
            s_d.run   = s_q.run | wrap;
            s_d.clk_o = (s_q.run | wrap) && ({1'b0, nxt} < half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_clk = s_q.clk_o;
endmodule

// File: rtl/sfg_frame.sv
// Stages two and three: frame period and pulse width, plus setting shadows.
module sfg_frame #(
    parameter int DIV_W = 8,
    parameter int FRM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync_en,
    input  logic             bit_tick,
    input  logic             resync,
    input  logic [DIV_W-1:0] div_in,
    input  logic [FRM_W-1:0] per_in,
    input  logic [FRM_W-1:0] wid_in,
    output logic             frame,
    output logic [DIV_W-1:0] div_cur
);
    localparam logic [FRM_W-1:0] FCNT_MAX = '1;

    typedef struct packed {
        logic [FRM_W-1:0] fcnt;
        logic             on;
        logic             run;
        logic [DIV_W-1:0] div_s;
        logic [FRM_W-1:0] per_s;
        logic [FRM_W-1:0] wid_s;
    } frm_st_t;

    frm_st_t          s_d, s_q;
    logic             start;
    logic [FRM_W-1:0] nxt;

    always_comb begin
        s_d   = s_q;
        start = 1'b0;
        nxt   = s_q.fcnt + 1'b1;
        if (sync_en && (s_q.fcnt == FCNT_MAX)) nxt = s_q.fcnt;
        if (!en) begin
            s_d       = '0;
            s_d.div_s = div_in;
            s_d.per_s = per_in;
            s_d.wid_s = wid_in;
        end else if (bit_tick) begin
            start = sync_en ? resync : (!s_q.run || (s_q.fcnt == s_q.per_s));
            if (start) begin
                s_d.fcnt  = '0;
                s_d.on    = 1'b1;
                s_d.run   = 1'b1;
                s_d.div_s = div_in;
                s_d.per_s = per_in;
                s_d.wid_s = wid_in;
            end else begin
                s_d.fcnt = nxt;
                s_d.on   = s_q.run && (nxt <= s_q.wid_s);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign frame   = s_q.on;
    assign div_cur = s_q.div_s;
endmodule

// File: rtl/sfg_top.sv
module sfg_top
    import sfg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int FRM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic [1:0]       src_mode,
    input  logic             ext_clk,
    input  logic             ext_pol,
    input  logic             rxc_pin,
    input  logic             rxc_pol,
    input  logic             txc_pin,
    input  logic             txc_pol,
    input  logic [DIV_W-1:0] div_val,
    input  logic [FRM_W-1:0] per_val,
    input  logic [FRM_W-1:0] wid_val,
    input  logic             sync_en,
    input  logic             fs_pin,
    input  logic             fs_pol,
    output logic             bit_clk,
    output logic             frame_sync
);
    localparam int NPIN = 3;

    logic [NPIN-1:0]  pin_v, pol_v, hit_v;
    logic             fs_hit, src_tick, resync, bit_tick;
    logic [DIV_W-1:0] div_cur;

    assign pin_v = {txc_pin, rxc_pin, ext_clk};
    assign pol_v = {txc_pol, rxc_pol, ext_pol};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        sfg_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_v[g]),
            .pol  (pol_v[g]),
            .hit  (hit_v[g])
        );
    end

    sfg_edge u_fs_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (fs_pin),
        .pol  (fs_pol),
        .hit  (fs_hit)
    );

    always_comb begin
        case (src_sel_e'(src_mode))
            SRC_SYS: src_tick = 1'b1;
            SRC_EXT: src_tick = hit_v[0];
            SRC_RXP: src_tick = hit_v[1];
            default: src_tick = hit_v[2];
        endcase
    end

    assign resync = sync_en & fs_hit;

    sfg_bitdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (gen_en),
        .tick    (src_tick),
        .resync  (resync),
        .div     (div_cur),
        .bit_clk (bit_clk),
        .bit_tick(bit_tick)
    );

    sfg_frame #(.DIV_W(DIV_W), .FRM_W(FRM_W)) u_frm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (gen_en),
        .sync_en (sync_en),
        .bit_tick(bit_tick),
        .resync  (resync),
        .div_in  (div_val),
        .per_in  (per_val),
        .wid_in  (wid_val),
        .frame   (frame_sync),
        .div_cur (div_cur)
    );
endmodule

// File: rtl/sfg_chk.sv
module sfg_chk (
    input logic clk,
    input logic rst_n,
    input logic gen_en,
    input logic sync_en,
    input logic src_tick,
    input logic resync,
    input logic bit_tick,
    input logic bit_clk,
    input logic frame_sync
);
    // R1
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (!bit_clk && !frame_sync));

    // R4
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en |=> ($stable(bit_clk) || $past(src_tick) || $past(resync)));

    // R6
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_en |=> ($stable(frame_sync) || $past(bit_tick)));

    // R9
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && sync_en) |=> (!$rose(frame_sync) || $past(resync)));
endmodule

bind sfg_top sfg_chk u_sfg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .sync_en   (sync_en),
    .src_tick  (src_tick),
    .resync    (resync),
    .bit_tick  (bit_tick),
    .bit_clk   (bit_clk),
    .frame_sync(frame_sync)
);

// File: tb/test_sfg_top.sv
`timescale 1ns/1ps
module test_sfg_top;
    localparam int DIV_W = 8;
    localparam int FRM_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gen_en = 1'b0;
    logic [1:0] src_mode = 2'b00;
    logic ext_clk = 1'b0, ext_pol = 1'b0;
    logic rxc_pin = 1'b0, rxc_pol = 1'b0;
    logic txc_pin = 1'b0, txc_pol = 1'b0;
    logic [DIV_W-1:0] div_val = '0;
    logic [FRM_W-1:0] per_val = '0, wid_val = '0;
    logic sync_en = 1'b0, fs_pin = 1'b0, fs_pol = 1'b0;
    logic bit_clk, frame_sync;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sfg_top #(.DIV_W(DIV_W), .FRM_W(FRM_W)) i_sfg_top (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .src_mode(src_mode),
        .ext_clk(ext_clk), .ext_pol(ext_pol), .rxc_pin(rxc_pin), .rxc_pol(rxc_pol),
        .txc_pin(txc_pin), .txc_pol(txc_pol), .div_val(div_val), .per_val(per_val),
        .wid_val(wid_val), .sync_en(sync_en), .fs_pin(fs_pin), .fs_pol(fs_pol),
        .bit_clk(bit_clk), .frame_sync(frame_sync)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic setup(input logic [1:0] mode, input int n, input int p, input int w,
                         input bit sy, input bit fpol);
        @(negedge clk);
        gen_en   = 1'b0;
        src_mode = mode;
        div_val  = DIV_W'(n);
        per_val  = FRM_W'(p);
        wid_val  = FRM_W'(w);
        sync_en  = sy;
        fs_pol   = fpol;
        fs_pin   = fpol;
        repeat (5) @(negedge clk);
        gen_en = 1'b1;
    endtask

    task automatic set_pins(input logic [1:0] mode, input logic sel_v, input logic oth_v);
        ext_clk = (mode == 2'b01) ? sel_v : oth_v;
        rxc_pin = (mode == 2'b10) ? sel_v : oth_v;
        txc_pin = (mode == 2'b11) ? sel_v : oth_v;
    endtask

    task automatic t_reset();
        chk("R1", int'(bit_clk), 0);
        chk("R1", int'(frame_sync), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1", int'(bit_clk), 0);
        chk("R1", int'(frame_sync), 0);
    endtask

    // System clock source; compares every sample with the period formulas.
    task automatic t_periodic(input int n, input int p, input int w, input bit fs_noise,
                              input string tagf);
        int h = (n + 2) / 2;
        int kmax = (n + 1) * (p + 1) * 3 + 2;
        setup(2'b00, n, p, w, 1'b0, 1'b0);
        for (int k = 1; k <= kmax; k++) begin
            int bc = 0, fr = 0;
            @(negedge clk);
            if (k >= n + 1) begin
                int m = k - (n + 1);
                bc = ((m % (n + 1)) < h) ? 1 : 0;
                fr = (((m / (n + 1)) % (p + 1)) <= w) ? 1 : 0;
            end
            if (k == n)     chk("R5", int'(bit_clk), 0);
            if (k == n + 1) chk("R5", int'(bit_clk), 1);
            chk("R4", int'(bit_clk), bc);
            chk(tagf, int'(frame_sync), fr);
            if (fs_noise && (k % 3 == 0)) fs_pin = ~fs_pin;
        end
        gen_en = 1'b0;
        @(negedge clk);
        chk("R1", int'(bit_clk), 0);
        chk("R1", int'(frame_sync), 0);
        fs_pin = 1'b0;
    endtask

    task automatic t_pin(input logic [1:0] mode, input logic pol);
        ext_pol = pol; rxc_pol = pol; txc_pol = pol;
        setup(mode, 0, 3, 0, 1'b0, 1'b0);
        for (int r = 0; r < 2; r++) begin
            set_pins(mode, 1'b0, 1'b1);
            repeat (4) @(negedge clk);
            set_pins(mode, 1'b0, 1'b0);
            repeat (4) @(negedge clk);
        end
        chk("R2", int'(bit_clk), 0);
        set_pins(mode, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        chk("R2", int'(bit_clk), 0);
        @(negedge clk);
        chk("R3", int'(bit_clk), (pol == 1'b0) ? 1 : 0);
        set_pins(mode, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R3", int'(bit_clk), 1);
        gen_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_pin_count();
        int rises = 0;
        logic prev = 1'b0;
        ext_pol = 1'b0;
        setup(2'b01, 2, 3, 0, 1'b0, 1'b0);
        for (int c = 0; c < 12; c++) begin
            for (int s = 0; s < 8; s++) begin
                ext_clk = (s < 4);
                @(negedge clk);
                if (bit_clk && !prev) rises++;
                prev = bit_clk;
            end
        end
        ext_clk = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (bit_clk && !prev) rises++;
            prev = bit_clk;
        end
        chk("R4", rises, 4);
        gen_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_shadow();
        logic prev = 1'b0;
        setup(2'b00, 1, 3, 0, 1'b0, 1'b0);
        for (int k = 1; k <= 20; k++) begin
            int rise, exp_rise;
            @(negedge clk);
            rise = (frame_sync && !prev) ? 1 : 0;
            exp_rise = (k == 2 || k == 10 || k == 14 || k == 18) ? 1 : 0;
            chk("R8", rise, exp_rise);
            prev = frame_sync;
            if (k == 3) per_val = FRM_W'(1);
        end
        gen_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_sync(input logic pol);
        int fr_seen = 0;
        setup(2'b00, 4, 3, 1, 1'b1, pol);
        for (int k = 1; k <= 13; k++) begin
            @(negedge clk);
            if (frame_sync) fr_seen++;
        end
        chk("R9", fr_seen, 0);
        fs_pin = ~pol;
        repeat (3) @(negedge clk);
        chk("R9", int'(bit_clk), 1);
        chk("R9", int'(frame_sync), 1);
        for (int j = 1; j <= 10; j++) begin
            @(negedge clk);
            if (j == 2) fs_pin = pol;
            if (j <= 5) chk("R9", int'(bit_clk), (j <= 2 || j == 5) ? 1 : 0);
            chk("R7", int'(frame_sync), (j <= 9) ? 1 : 0);
        end
        fr_seen = 0;
        repeat (60) begin
            @(negedge clk);
            if (frame_sync) fr_seen++;
        end
        chk("R9", fr_seen, 0);
        gen_en  = 1'b0;
        sync_en = 1'b0;
        fs_pin  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL (all requirements) watchdog: actual still running, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_periodic(3, 3, 0, 1'b0, "R6");
        t_periodic(4, 2, 1, 1'b1, "R10");
        t_pin(2'b01, 1'b0);
        t_pin(2'b10, 1'b1);
        t_pin(2'b11, 1'b0);
        t_pin(2'b01, 1'b1);
        t_pin_count();
        t_shadow();
        t_sync(1'b0);
        t_sync(1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule